// File: doc/BRIEF.md
# ADC Serial Result Reader

This block is the host end of a three-wire link to a 12-bit serial converter. It drives a frame line that stays high for the whole read and a serial clock that idles low. It samples the converter's data line on every rising serial-clock edge. The serial clock comes from the system clock through a fixed divider. The low and high phases each last half of one divided period.

A one-cycle start pulse begins a read, and a mode input chooses the framing. In byte mode the read is two 8-clock bytes separated by a low gap. The first byte holds D11..D4. The second byte carries D3..D0 in its first four clocks, and its last four clocks are discarded. In word mode the read is a single burst of `WORD_CLKS` clocks (12 to 16). The first 12 captured bits form the result, and anything sampled after them is ignored. When the read finishes, busy drops and a one-cycle valid strobe presents the result right-justified and zero-extended.

Top module: `adc_result_reader`

## Requirements
- R1: After reset, sclk_o, frame_o, busy_o and valid_o are 0 and result_o is 0.
- R2: sclk_o is low whenever no read is running. During a read, every high phase of sclk_o lasts exactly DIV/2 system clocks. Every low phase inside a frame, including the first one after frame_o rises, also lasts DIV/2 system clocks.
- R3: Data is sampled from sdata_i only at rising edges of sclk_o, and bits arrive MSB first. The first captured bit is D11.
- R4: With word_mode_i = 0 (byte mode), a read has exactly 16 rising edges of sclk_o in two groups of 8. Result bits D11..D4 come from rising edges 1..8. Bits D3..D0 come from rising edges 9..12. Rising edges 13..16 are discarded.
- R5: In byte mode, sclk_o stays low between the two bytes for 3*DIV/2 system clocks. That is one full divided period plus the normal low phase. The gap does not change the captured bits.
- R6: With word_mode_i = 1, a read has exactly WORD_CLKS rising edges with no gap. The first 12 bits form the result, and later bits are ignored whatever their value.
- R7: busy_o is 1 from the cycle after an accepted start until the last high phase of sclk_o ends. valid_o is then 1 for exactly one cycle with busy_o = 0. result_o holds the 12-bit result in bits [11:0] and zeros above.
- R8: A start_i pulse while a read is in progress (busy_o = 1) is ignored. The running read keeps its clock count and mode, and only one valid_o pulse follows.
- R9: frame_o is 1 from the cycle after start through the valid cycle. sclk_o is never high while frame_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a read |
| word_mode_i | input | 1 | 0: two 8-clock bytes; 1: one WORD_CLKS burst (latched at start) |
| sdata_i | input | 1 | Serial data from the converter |
| frame_o | output | 1 | Conversion-start / frame line, high during a read |
| sclk_o | output | 1 | Serial clock, idles low |
| busy_o | output | 1 | Read in progress |
| valid_o | output | 1 | One-cycle strobe, result_o valid |
| result_o | output | OUT_W (16) | Zero-extended 12-bit result |

## Verification
The bench builds the block with DIV = 4 and WORD_CLKS = 14. At these settings one transfer takes about 70 system clocks, so a sweep of result codes at a stride of 13 in both framings fits comfortably. The sweep also includes the all-ones and all-zeros codes. Because 14 is not 16, word mode must stop at a frame length different from byte mode. The bench's converter model drives 1s after the twelfth bit, so a wrongly captured trailing bit changes the result. Phase and gap lengths are measured on the sclk_o pin for every transfer, and every fifth read receives an extra start pulse mid-frame.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_DONE
    } rd_state_e;
endpackage

// File: rtl/adc_rd_phase.sv
module adc_rd_phase #(
    parameter int HALF = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clear_i,
    output logic last_o
);
    localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [PW-1:0] ph_d, ph_q;

    assign last_o = run_i && (ph_q == PW'(HALF - 1));

    always_comb begin
        ph_d = ph_q;
        if (clear_i) begin
            ph_d = '0;
        end else if (run_i) begin
            ph_d = last_o ? '0 : ph_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    // R2: the phase counter never passes the half-period length
    p_phase_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q <= PW'(HALF - 1));
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [RES_W-1:0] data_o
);
    logic [RES_W-1:0] data_d, data_q;

    assign data_o = data_q;

    always_comb begin
        data_d = data_q;
        if (clear_i)      data_d = '0;
        else if (shift_i) data_d = {data_q[RES_W-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    // R6: without a shift or clear request the captured bits do not move
    p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_i && !clear_i) |=> $stable(data_q));
endmodule

// File: rtl/adc_result_reader.sv
module adc_result_reader
    import adc_rd_pkg::*;
#(
    parameter int DIV       = 16,
    parameter int WORD_CLKS = 16,
    parameter int RES_W     = 12,
    parameter int OUT_W     = 16,
    parameter int BYTE_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             word_mode_i,
    input  logic             sdata_i,
    output logic             frame_o,
    output logic             sclk_o,
    output logic             busy_o,
    output logic             valid_o,
    output logic [OUT_W-1:0] result_o
);
    localparam int HALF   = DIV / 2;
    localparam int BCLKS  = 2 * BYTE_W;
    localparam int MAXCLK = (WORD_CLKS > BCLKS) ? WORD_CLKS : BCLKS;
    localparam int KW     = $clog2(MAXCLK + 1);
    localparam int PAD    = OUT_W - RES_W;

    typedef struct packed {
        rd_state_e        st;
        logic [KW-1:0]    k;
        logic             mode;
        logic             gap;
        logic             sclk;
        logic             frame;
        logic             busy;
        logic             valid;
        logic [RES_W-1:0] res;
    } regs_t;

    regs_t r_d, r_q;

    logic             tick;
    logic             ph_run;
    logic             ph_clear;
    logic             cap_clear;
    logic             cap_shift;
    logic [RES_W-1:0] cap_data;
    logic             last_clk;
    logic             byte_end;

    adc_rd_phase #(.HALF(HALF)) i_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (ph_run),
        .clear_i (ph_clear),
        .last_o  (tick)
    );

    adc_rd_shift #(.RES_W(RES_W)) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cap_clear),
        .shift_i (cap_shift),
        .bit_i   (sdata_i),
        .data_o  (cap_data)
    );

    assign ph_run   = (r_q.st == ST_LOW) || (r_q.st == ST_HIGH) || (r_q.st == ST_GAP);
    assign ph_clear = (r_q.st == ST_IDLE);
    assign last_clk = r_q.mode ? (r_q.k == KW'(WORD_CLKS - 1)) : (r_q.k == KW'(BCLKS - 1));
    assign byte_end = !r_q.mode && (r_q.k == KW'(BYTE_W - 1));

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        cap_clear = 1'b0;
        cap_shift = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st    = ST_LOW;
                    r_d.k     = '0;
                    r_d.mode  = word_mode_i;
                    r_d.gap   = 1'b0;
                    r_d.frame = 1'b1;
                    r_d.busy  = 1'b1;
                    cap_clear = 1'b1;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    r_d.st    = ST_HIGH;
                    r_d.sclk  = 1'b1;
                    cap_shift = (r_q.k < KW'(RES_W));
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    r_d.sclk = 1'b0;
                    r_d.k    = r_q.k + KW'(1);
                    if (last_clk) begin
                        r_d.st    = ST_DONE;
                        r_d.busy  = 1'b0;
                        r_d.valid = 1'b1;
                        r_d.res   = cap_data;
                    end else if (byte_end) begin
                        r_d.st  = ST_GAP;
                        r_d.gap = 1'b0;
                    end else begin
                        r_d.st = ST_LOW;
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (r_q.gap) begin
                        r_d.st  = ST_LOW;
                        r_d.gap = 1'b0;
                    end else begin
                        r_d.gap = 1'b1;
                    end
                end
            end
            ST_DONE: begin
                r_d.st    = ST_IDLE;
                r_d.frame = 1'b0;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign frame_o = r_q.frame;
    assign sclk_o  = r_q.sclk;
    assign busy_o  = r_q.busy;
    assign valid_o = r_q.valid;

    generate
        if (PAD > 0) begin : g_pad
            assign result_o = {{PAD{1'b0}}, r_q.res};
        end else begin : g_nopad
            assign result_o = r_q.res[OUT_W-1:0];
        end
    endgenerate

    // R7: the valid strobe lasts a single cycle
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R7: valid never coincides with busy
    p_valid_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !busy_o);

    // R9: the serial clock only runs inside a frame
    p_sclk_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> frame_o);

    // R8: the latched framing mode cannot change while a read runs
    p_mode_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(r_q.mode));

    // R6: the clock counter never runs past the longest frame
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.k <= KW'(MAXCLK));
endmodule

// File: tb/test_adc_result_reader.sv
module test_adc_result_reader;
    localparam int DIV   = 4;
    localparam int HALF  = DIV / 2;
    localparam int WCLKS = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        word_mode_i = 1'b0;
    logic        sdata_i = 1'b1;
    logic        frame_o, sclk_o, busy_o, valid_o;
    logic [15:0] result_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    adc_result_reader #(.DIV(DIV), .WORD_CLKS(WCLKS)) i_adc_result_reader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_mode_i(word_mode_i),
        .sdata_i(sdata_i), .frame_o(frame_o), .sclk_o(sclk_o), .busy_o(busy_o),
        .valid_o(valid_o), .result_o(result_o)
    );

    // converter model: first bit ready at frame start, next bit on each falling sclk
    logic [11:0] adc_word = '0;
    int adc_idx = 0;
    always @(posedge frame_o) begin
        adc_idx = 0;
        sdata_i = adc_word[11];
    end
    always @(negedge sclk_o) begin
        if (frame_o) begin
            adc_idx = adc_idx + 1;
            sdata_i = (adc_idx < 12) ? adc_word[11 - adc_idx] : 1'b1;
        end
    end

    // pin monitor
    int rise_cnt, valid_cnt, hi_run, low_run, hi_bad, min_low, max_low, idle_hi;
    logic prev_s = 1'b0;
    always @(negedge clk) begin
        if (sclk_o && !prev_s) begin
            rise_cnt = rise_cnt + 1;
            if (low_run < min_low) min_low = low_run;
            if (low_run > max_low) max_low = low_run;
            low_run = 0;
        end
        if (!sclk_o && prev_s) begin
            if (hi_run != HALF) hi_bad = hi_bad + 1;
            hi_run = 0;
        end
        if (sclk_o) hi_run = hi_run + 1;
        else if (frame_o) low_run = low_run + 1;
        if (sclk_o && !frame_o) idle_hi = idle_hi + 1;
        if (valid_o) valid_cnt = valid_cnt + 1;
        prev_s = sclk_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [11:0] v, input logic mode, input bit extra);
        int waited;
        bit seen;
        logic [15:0] got;
        adc_word  = v;
        rise_cnt  = 0; valid_cnt = 0; hi_run = 0; low_run = 0;
        hi_bad    = 0; min_low = 1000; max_low = 0;
        @(negedge clk);
        start_i = 1'b1; word_mode_i = mode;
        @(negedge clk);
        start_i = 1'b0; word_mode_i = ~mode;
        chk(busy_o === 1'b1, "R7 busy after start", int'(busy_o), 1);
        chk(frame_o === 1'b1, "R9 frame after start", int'(frame_o), 1);
        if (extra) begin
            repeat (10) @(negedge clk);
            start_i = 1'b1; word_mode_i = ~mode;
            @(negedge clk);
            start_i = 1'b0;
        end
        seen = 1'b0; waited = 0; got = '0;
        while (!seen && waited < 2000) begin
            @(negedge clk);
            waited = waited + 1;
            if (valid_o) begin
                seen = 1'b1;
                got  = result_o;
                chk(busy_o === 1'b0, "R7 busy low at valid", int'(busy_o), 0);
                chk(frame_o === 1'b1, "R9 frame during valid", int'(frame_o), 1);
            end
        end
        chk(seen, "R7 valid arrives", int'(seen), 1);
        chk(got == {4'b0, v}, mode ? "R6 word result" : "R4 byte result", int'(got), int'(v));
        repeat (HALF + 4) @(negedge clk);
        chk(rise_cnt == (mode ? WCLKS : 16), mode ? "R6 clock count" : "R4 clock count",
            rise_cnt, mode ? WCLKS : 16);
        chk(valid_cnt == 1, extra ? "R8 single valid" : "R7 single valid", valid_cnt, 1);
        chk(hi_bad == 0, "R2 high phase length", hi_bad, 0);
        chk(min_low == HALF, "R2 low phase length", min_low, HALF);
        chk(max_low == (mode ? HALF : 3 * HALF), mode ? "R2 no gap in word mode" : "R5 byte gap",
            max_low, mode ? HALF : 3 * HALF);
        chk(!busy_o && !frame_o && !sclk_o, "R2 idle after read",
            int'({busy_o, frame_o, sclk_o}), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle_hi = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sclk_o === 1'b0 && frame_o === 1'b0, "R1 sclk/frame reset",
            int'({sclk_o, frame_o}), 0);
        chk(busy_o === 1'b0 && valid_o === 1'b0, "R1 busy/valid reset",
            int'({busy_o, valid_o}), 0);
        chk(result_o === 16'h0, "R1 result reset", int'(result_o), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(sclk_o === 1'b0, "R2 idle low", int'(sclk_o), 0);

        // corner codes, MSB-first ordering (R3)
        do_read(12'hFFF, 1'b0, 1'b0);
        do_read(12'h000, 1'b0, 1'b0);
        do_read(12'h800, 1'b1, 1'b0);
        do_read(12'h001, 1'b1, 1'b0);
        do_read(12'h00F, 1'b0, 1'b0);
        do_read(12'hA5C, 1'b1, 1'b1);

        // R3 R4 R6 R8 sweep over codes in both framings
        for (int v = 0; v < 4096; v += 13) begin
            do_read(12'(v), 1'b0, (v % 5) == 0);
            do_read(12'(v), 1'b1, (v % 5) == 1);
        end

        chk(idle_hi == 0, "R9 sclk only inside frame", idle_hi, 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule